// File: doc/BRIEF.md
# Fault-Tolerant Cache Line Repair Reader

This block sits on the read path of a two-bank cache whose SRAM cells may fail at low supply voltage. Each cache line is cut into equal chunks. A per-line fault map records which chunks hold bad cells. Lines whose faulty chunks never share a position form a group. Each group also owns one spare line, which is placed in the opposite bank to the lines it serves.

On a read, the block turns the requested address into the address of the group's spare line at once. This lets the other bank be read in the same cycle. When both raw lines arrive, a chunk multiplexer takes each faulty chunk from the same position in the spare line and every other chunk from the data line. The result is registered and returned one clock later.

In high-power mode no cells fail, so the line passes straight through. The fault map and the line-to-spare map are filled through a small configuration write port while the cache is idle. A line marked unusable returns a miss instead of data.

Top module: `chunk_repair_reader`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_line are zero. Every line has an empty fault map, spare pointer 0 and is enabled, so a low-power read returns the data line unchanged with rsp_hit=1.
- R2: rsp_valid equals rd_valid delayed by exactly one clock. rsp_hit and rsp_line belong to the read accepted on the previous edge.
- R3: spare_addr is combinational from rd_addr. Its most significant bit is the inverse of rd_addr's most significant bit, and its lower bits are the spare pointer stored for rd_addr.
- R4: In low-power mode, chunk c of rsp_line (bits c*CHUNK_W to c*CHUNK_W+CHUNK_W-1) comes from the spare line when fault bit c of the addressed line is 1, and from the data line when it is 0.
- R5: The data line is bank0_line when rd_addr's most significant bit is 0, and bank1_line when it is 1. The spare line is the other bank's input.
- R6: In high-power mode (low_power=0), rsp_line equals the data line and rsp_hit=1, whatever the fault map and disable bit hold.
- R7: In low-power mode, a read of a line whose disable bit is set gives rsp_hit=0 and rsp_line all zeros.
- R8: A configuration write in a cycle where rd_valid is 1 is dropped and leaves the maps unchanged.
- R9: A configuration write takes effect for a read issued on the next clock.
- R10: In a cycle where rsp_valid is 0, rsp_hit is 0 and rsp_line is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_power | input | 1 | 1 enables chunk repair; 0 selects pass-through |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Line being configured |
| cfg_fault | input | CHUNKS | Fault bits, one per chunk |
| cfg_spare | input | AW-1 | Spare line index within the opposite bank |
| cfg_dis | input | 1 | Marks the line unusable |
| rd_valid | input | 1 | Read request |
| rd_addr | input | AW | Line address; MSB selects the data bank |
| spare_addr | output | AW | Address of the spare line in the opposite bank |
| bank0_line | input | LW | Raw line from bank 0 for this read |
| bank1_line | input | LW | Raw line from bank 1 for this read |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Response carries usable data |
| rsp_line | output | LW | Repaired line |

## Verification
spare_addr is combinational, so the bench checks it in the same cycle the read address is driven, before the clock edge. Every registered result (rsp_valid, rsp_hit, rsp_line) is due one edge after the read. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge. A configuration write is sampled on one rising edge and used by a read on the following edge, and the check for R9 relies on that order. The idle-cycle checks sample one edge after rd_valid falls.

// File: rtl/chunk_repair_reader.sv
module chunk_repair_reader #(
  parameter int LINES   = 16,
  parameter int CHUNKS  = 8,
  parameter int CHUNK_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            low_power,
  input  logic                            cfg_we,
  input  logic [$clog2(LINES)-1:0]        cfg_addr,
  input  logic [CHUNKS-1:0]               cfg_fault,
  input  logic [$clog2(LINES)-2:0]        cfg_spare,
  input  logic                            cfg_dis,
  input  logic                            rd_valid,
  input  logic [$clog2(LINES)-1:0]        rd_addr,
  output logic [$clog2(LINES)-1:0]        spare_addr,
  input  logic [CHUNKS*CHUNK_W-1:0]       bank0_line,
  input  logic [CHUNKS*CHUNK_W-1:0]       bank1_line,
  output logic                            rsp_valid,
  output logic                            rsp_hit,
  output logic [CHUNKS*CHUNK_W-1:0]       rsp_line
);
  localparam int AW = $clog2(LINES);
  localparam int PW = AW - 1;
  localparam int LW = CHUNKS * CHUNK_W;

  logic [CHUNKS-1:0] fault_q [LINES];
  logic [PW-1:0]     spare_q [LINES];
  logic [LINES-1:0]  dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        fault_q[i] <= '0;
        spare_q[i] <= '0;
      end
      dis_q <= '0;
    end else if (cfg_we && !rd_valid) begin
      fault_q[cfg_addr] <= cfg_fault;
      spare_q[cfg_addr] <= cfg_spare;
      dis_q[cfg_addr]   <= cfg_dis;
    end
  end

  logic          hi_bank;
  logic [LW-1:0] data_line, spare_line, merged;
  logic          miss;

  assign hi_bank    = rd_addr[AW-1];
  assign spare_addr = {~hi_bank, spare_q[rd_addr]};
  assign data_line  = hi_bank ? bank1_line : bank0_line;
  assign spare_line = hi_bank ? bank0_line : bank1_line;
  assign miss       = low_power && dis_q[rd_addr];

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    assign merged[c*CHUNK_W +: CHUNK_W] = (low_power && fault_q[rd_addr][c]) ?
      spare_line[c*CHUNK_W +: CHUNK_W] : data_line[c*CHUNK_W +: CHUNK_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_line  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      rsp_hit   <= rd_valid && !miss;
      rsp_line  <= (rd_valid && !miss) ? merged : '0;
    end
  end
endmodule

// File: rtl/chunk_repair_reader_chk.sv
module chunk_repair_reader_chk #(
  parameter int AW = 4,
  parameter int LW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          low_power,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] spare_addr,
  input logic [LW-1:0] bank0_line,
  input logic [LW-1:0] bank1_line,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [LW-1:0] rsp_line
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid); // R2
  AST_SPARE_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> spare_addr[AW-1] != rd_addr[AW-1]); // R3
  AST_HIGH_POWER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !low_power) |=>
      (rsp_hit && rsp_line == ($past(rd_addr[AW-1]) ? $past(bank1_line) : $past(bank0_line)))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && rsp_line == '0)); // R10
endmodule

bind chunk_repair_reader chunk_repair_reader_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .low_power(low_power), .rd_valid(rd_valid),
  .rd_addr(rd_addr), .spare_addr(spare_addr), .bank0_line(bank0_line),
  .bank1_line(bank1_line), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_line(rsp_line)
);

// File: tb/chunk_repair_reader_bench.sv
`timescale 1ns/1ps
module chunk_repair_reader_bench;
  logic        clk = 0, rst_n = 0, low_power = 0;
  logic        cfg_we = 0, cfg_dis = 0, rd_valid = 0;
  logic [3:0]  cfg_addr = 0, rd_addr = 0, spare_addr;
  logic [7:0]  cfg_fault = 0;
  logic [2:0]  cfg_spare = 0;
  logic [63:0] bank0_line = 0, bank1_line = 0, rsp_line;
  logic        rsp_valid, rsp_hit;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chunk_repair_reader u_chunk_repair_reader (
    .clk(clk), .rst_n(rst_n), .low_power(low_power), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_fault(cfg_fault), .cfg_spare(cfg_spare),
    .cfg_dis(cfg_dis), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .spare_addr(spare_addr), .bank0_line(bank0_line), .bank1_line(bank1_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_line(rsp_line));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] repair(logic [63:0] d, logic [63:0] s, logic [7:0] f);
    logic [63:0] r;
    for (int c = 0; c < 8; c++) r[c*8 +: 8] = f[c] ? s[c*8 +: 8] : d[c*8 +: 8];
    return r;
  endfunction

  task automatic cfg_write(logic [3:0] a, logic [7:0] f, logic [2:0] s, logic d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_fault = f; cfg_spare = s; cfg_dis = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic read_chk(string req, logic [3:0] a, logic lp, logic [63:0] b0, logic [63:0] b1,
                          logic [3:0] exp_sp, logic exp_hit, logic [63:0] exp_line);
    @(negedge clk);
    rd_valid = 1; rd_addr = a; low_power = lp; bank0_line = b0; bank1_line = b1;
    #1 check({req, " spare_addr"}, 64'(spare_addr), 64'(exp_sp));
    @(posedge clk); #1;
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " hit"}, 64'(rsp_hit), 64'(exp_hit));
    check({req, " line"}, rsp_line, exp_line);
    @(negedge clk); rd_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 valid", 64'(rsp_valid), 0);
    check("R1 hit", 64'(rsp_hit), 0);
    check("R1 line", rsp_line, 0);
    read_chk("R1 empty map", 4'd3, 1, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD,
             4'd8, 1, 64'h1111_2222_3333_4444);
  endtask

  task automatic t_low_bank;
    logic [63:0] d = 64'h0102_0304_0506_0708, s = 64'hF1F2_F3F4_F5F6_F7F8;
    cfg_write(4'd2, 8'hA5, 3'd5, 0);
    read_chk("R4 R3 low bank", 4'd2, 1, d, s, 4'd13, 1, repair(d, s, 8'hA5));
  endtask

  task automatic t_high_bank;
    logic [63:0] s = 64'h9999_8888_7777_6666, d = 64'h0F0E_0D0C_0B0A_0908;
    cfg_write(4'd12, 8'h81, 3'd1, 0);
    read_chk("R5 high bank", 4'd12, 1, s, d, 4'd1, 1, repair(d, s, 8'h81));
  endtask

  task automatic t_high_power;
    read_chk("R6 pass", 4'd2, 0, 64'hDEAD_BEEF_0000_1111, 64'h5555_5555_5555_5555,
             4'd13, 1, 64'hDEAD_BEEF_0000_1111);
  endtask

  task automatic t_disabled;
    cfg_write(4'd7, 8'h0F, 3'd2, 1);
    read_chk("R7 miss", 4'd7, 1, 64'h1234_5678_9ABC_DEF0, 64'h1, 4'd10, 0, 64'd0);
    read_chk("R6 disabled pass", 4'd7, 0, 64'h1234_5678_9ABC_DEF0, 64'h1, 4'd10, 1,
             64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_write_during_read;
    @(negedge clk);
    rd_valid = 1; rd_addr = 4'd3; low_power = 1; bank0_line = 64'h1; bank1_line = 64'h2;
    cfg_we = 1; cfg_addr = 4'd4; cfg_fault = 8'hFF; cfg_spare = 3'd6; cfg_dis = 1;
    @(negedge clk);
    rd_valid = 0; cfg_we = 0;
    read_chk("R8 dropped", 4'd4, 1, 64'hCAFE_0000_CAFE_0000, 64'hFFFF_FFFF_FFFF_FFFF,
             4'd8, 1, 64'hCAFE_0000_CAFE_0000);
  endtask

  task automatic t_idle;
    read_chk("R2 read", 4'd0, 1, 64'h77, 64'h88, 4'd8, 1, 64'h77);
    @(posedge clk); #1;
    check("R2 valid drop", 64'(rsp_valid), 0);
    check("R10 hit idle", 64'(rsp_hit), 0);
    check("R10 line idle", rsp_line, 0);
  endtask

  task automatic t_write_then_read;
    logic [63:0] d = 64'h2468_ACE0_1357_9BDF, s = 64'hFEDC_BA98_7654_3210;
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'd9; cfg_fault = 8'h0F; cfg_spare = 3'd3; cfg_dis = 0;
    @(negedge clk);
    cfg_we = 0;
    rd_valid = 1; rd_addr = 4'd9; low_power = 1; bank0_line = s; bank1_line = d;
    #1 check("R9 spare_addr", 64'(spare_addr), 64'd3);
    @(posedge clk); #1;
    check("R9 line", rsp_line, repair(d, s, 8'h0F));
    @(negedge clk); rd_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset_pre();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_low_bank();
    t_high_bank();
    t_high_power();
    t_disabled();
    t_write_during_read();
    t_idle();
    t_write_then_read();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic t_reset_pre;
    check("R1 in reset valid", 64'(rsp_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule